// File: doc/BRIEF.md
# Candidate Motion Vector Matcher

This block picks the best of a short list of candidate motion vectors for one square luminance macroblock. The list comes from an outside vector-proposal engine. The block keeps two local stores. The first holds a search window taken from the previous reconstructed frame. The second holds the pixels of the current macroblock. Each candidate is scored by the sum of absolute differences (SAD) between the current block and the displaced reference block. The reference block is sampled at half-pixel precision using bilinear averaging.

Candidates arrive one at a time through a valid/ready handshake. A candidate inside the window is scored at one pixel per cycle. A candidate whose footprint leaves the window is not scored: it takes the largest possible SAD code at once. When the last candidate of a set has been scored, a one-cycle done pulse appears together with the winning vector and its SAD. These outputs stay unchanged until the next set completes. The window and current-block stores are filled through simple write ports before a set is started.

Top module: `mv_cand_matcher`

## Requirements
- R1: After reset, cand_ready is 1, done is 0, and best_x, best_y and best_sad are all 0.
- R2: cand_x and cand_y are two's-complement vectors in half-pixel units. Bit 0 is the half-pixel flag, and the integer part is the value shifted right arithmetically by one. The current block has its top-left pixel at window row V_RANGE, column H_NEG. For an integer vector, current pixel (r,c) is compared with window[V_RANGE+r+iy][H_NEG+c+ix].
- R3: Half-pixel samples are built from A=window[row][col], its right neighbour B, its lower neighbour C and its diagonal neighbour D. Horizontal half only gives (A+B+1)>>1. Vertical half only gives (A+C+1)>>1. Both halves give (A+B+C+D+2)>>2.
- R4: The score of an in-window candidate is the sum of |current - reference| over all MB_DIM*MB_DIM pixels. Pixels are 8-bit unsigned and the sum is SAD_W bits wide.
- R5: A candidate is inside the window when x lies in [-2*H_NEG, 2*H_POS] and y lies in [-2*V_RANGE, 2*V_RANGE] (by default -16..14 and -12..12). Any other candidate is scored as all ones (0xFFFF). It uses no pixel cycles, and cand_ready stays 1 in the next cycle.
- R6: A set holds exactly NUM_CAND (5) candidates. One cycle after the last one is scored, done is 1 for exactly one cycle. best_x, best_y and best_sad change only at that pulse.
- R7: The reported vector is the candidate with the smallest score. On equal scores the earlier candidate wins. If every candidate is outside the window, the first candidate is reported with 0xFFFF.
- R8: A candidate is taken on a rising edge where cand_valid and cand_ready are both 1. After an in-window candidate is taken, cand_ready stays 0 for exactly MB_DIM*MB_DIM cycles. cand_valid has no effect while cand_ready is 0.
- R9: win_we writes win_data into the window at (win_row, win_col). cur_we writes cur_data into the current block at (cur_row, cur_col). Row 0 is the top row and column 0 is the left column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_we | input | 1 | Window store write enable |
| win_row | input | clog2(MB_DIM+2*V_RANGE) | Window write row |
| win_col | input | clog2(MB_DIM+H_NEG+H_POS) | Window write column |
| win_data | input | PIX_W | Window write pixel |
| cur_we | input | 1 | Current block write enable |
| cur_row | input | clog2(MB_DIM) | Current block write row |
| cur_col | input | clog2(MB_DIM) | Current block write column |
| cur_data | input | PIX_W | Current block write pixel |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Block can take a candidate |
| cand_x | input | MV_W | Candidate horizontal vector, half-pixel units |
| cand_y | input | MV_W | Candidate vertical vector, half-pixel units |
| done | output | 1 | One-cycle pulse: set finished |
| best_x | output | MV_W | Winning horizontal vector |
| best_y | output | MV_W | Winning vertical vector |
| best_sad | output | SAD_W | Score of the winning vector |

## Verification
Every half-pixel position in and around the window of a reduced configuration is scored on its own, followed by four out-of-window fillers. Each position is tried under three window contents:
- a linear ramp, which shows errors in integer addressing;
- a hashed texture, which shows a wrong neighbour choice in the half-pixel averages;
- a 0/255 checkerboard, which drives every average onto a rounding boundary and pushes the sum to its largest values.

Sliding groups of five over the same positions check the minimum search. A flat picture makes every score equal, which checks that the earliest candidate wins a tie. A bogus offer held during scoring, the busy length, the pulse width and the hold of the outputs across a partial set cover the handshake.

// File: rtl/mvm_pkg.sv
package mvm_pkg;

    // Scoring controller states
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SCORE = 1'b1
    } mvm_state_e;

endpackage

// File: rtl/mvm_store.sv
// Pixel store with one write port and NRD combinational read ports.
module mvm_store #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int DW   = 8,
    parameter int NRD  = 1
) (
    input  logic                                clk,
    input  logic                                we,
    input  logic [$clog2(ROWS)-1:0]             wr_row,
    input  logic [$clog2(COLS)-1:0]             wr_col,
    input  logic [DW-1:0]                       wr_data,
    input  logic [NRD-1:0][$clog2(ROWS)-1:0]    rd_row,
    input  logic [NRD-1:0][$clog2(COLS)-1:0]    rd_col,
    output logic [NRD-1:0][DW-1:0]              rd_data
);
    localparam int  RAW      = $clog2(ROWS);
    localparam int  CAW      = $clog2(COLS);
    localparam bit  ROW_FULL = (ROWS == (1 << RAW));
    localparam bit  COL_FULL = (COLS == (1 << CAW));

    logic [DW-1:0] mem_q [ROWS][COLS];
    logic          wr_row_ok;
    logic          wr_col_ok;

    // Address guards exist only when a dimension is not a power of two
    if (ROW_FULL) begin : g_wr_rf
        assign wr_row_ok = 1'b1;
    end else begin : g_wr_rp
        assign wr_row_ok = (wr_row < RAW'(ROWS));
    end
    if (COL_FULL) begin : g_wr_cf
        assign wr_col_ok = 1'b1;
    end else begin : g_wr_cp
        assign wr_col_ok = (wr_col < CAW'(COLS));
    end

    always_ff @(posedge clk) begin
        if (we && wr_row_ok && wr_col_ok) begin
            mem_q[wr_row][wr_col] <= wr_data;
        end
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        logic row_ok;
        logic col_ok;
        if (ROW_FULL) begin : g_rf
            assign row_ok = 1'b1;
        end else begin : g_rp
            assign row_ok = (rd_row[i] < RAW'(ROWS));
        end
        if (COL_FULL) begin : g_cf
            assign col_ok = 1'b1;
        end else begin : g_cp
            assign col_ok = (rd_col[i] < CAW'(COLS));
        end
        assign rd_data[i] = (row_ok && col_ok) ? mem_q[rd_row[i]][rd_col[i]] : '0;
    end

endmodule

// File: rtl/mvm_halfpel.sv
// Bilinear half-pixel sample and absolute difference against the current pixel.
module mvm_halfpel #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] s_a,
    input  logic [DW-1:0] s_b,
    input  logic [DW-1:0] s_c,
    input  logic [DW-1:0] s_d,
    input  logic          frac_h,
    input  logic          frac_v,
    input  logic [DW-1:0] cur_pix,
    output logic [DW-1:0] abs_diff
);
    logic [DW+1:0] sum_h;
    logic [DW+1:0] sum_v;
    logic [DW+1:0] sum_q;
    logic [DW-1:0] pred;

    always_comb begin
        sum_h = {2'b00, s_a} + {2'b00, s_b} + (DW+2)'(1);
        sum_v = {2'b00, s_a} + {2'b00, s_c} + (DW+2)'(1);
        sum_q = {2'b00, s_a} + {2'b00, s_b} + {2'b00, s_c} + {2'b00, s_d} + (DW+2)'(2);
        unique case ({frac_v, frac_h})
            2'b01:   pred = sum_h[DW:1];
            2'b10:   pred = sum_v[DW:1];
            2'b11:   pred = sum_q[DW+1:2];
            default: pred = s_a;
        endcase
        abs_diff = (cur_pix >= pred) ? (cur_pix - pred) : (pred - cur_pix);
    end

endmodule

// File: rtl/mvm_range_check.sv
// Decides whether a half-pixel vector keeps the footprint inside the window.
module mvm_range_check #(
    parameter int MV_W    = 6,
    parameter int H_NEG   = 8,
    parameter int H_POS   = 7,
    parameter int V_RANGE = 6
) (
    input  logic [MV_W-1:0] vec_x,
    input  logic [MV_W-1:0] vec_y,
    output logic            in_range
);
    int sx;
    int sy;

    always_comb begin
        sx       = int'($signed(vec_x));
        sy       = int'($signed(vec_y));
        in_range = (sx >= -2 * H_NEG) && (sx <= 2 * H_POS) &&
                   (sy >= -2 * V_RANGE) && (sy <= 2 * V_RANGE);
    end

endmodule

// File: rtl/mv_cand_matcher.sv
module mv_cand_matcher
    import mvm_pkg::*;
#(
    parameter int MB_DIM   = 16,
    parameter int V_RANGE  = 6,
    parameter int H_NEG    = 8,
    parameter int H_POS    = 7,
    parameter int NUM_CAND = 5,
    parameter int PIX_W    = 8,
    parameter int SAD_W    = 16,
    parameter int MV_W     = 6
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          win_we,
    input  logic [$clog2(MB_DIM+2*V_RANGE)-1:0]           win_row,
    input  logic [$clog2(MB_DIM+H_NEG+H_POS)-1:0]         win_col,
    input  logic [PIX_W-1:0]                              win_data,
    input  logic                                          cur_we,
    input  logic [$clog2(MB_DIM)-1:0]                     cur_row,
    input  logic [$clog2(MB_DIM)-1:0]                     cur_col,
    input  logic [PIX_W-1:0]                              cur_data,
    input  logic                                          cand_valid,
    output logic                                          cand_ready,
    input  logic [MV_W-1:0]                               cand_x,
    input  logic [MV_W-1:0]                               cand_y,
    output logic                                          done,
    output logic [MV_W-1:0]                               best_x,
    output logic [MV_W-1:0]                               best_y,
    output logic [SAD_W-1:0]                              best_sad
);
    localparam int WIN_H   = MB_DIM + 2 * V_RANGE;
    localparam int WIN_W   = MB_DIM + H_NEG + H_POS;
    localparam int RAW     = $clog2(WIN_H);
    localparam int CAW     = $clog2(WIN_W);
    localparam int MAW     = $clog2(MB_DIM);
    localparam int CNT_W   = $clog2(NUM_CAND + 1);
    localparam int IDX_W   = 16;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef struct packed {
        mvm_state_e        state;
        logic [MV_W-1:0]   vec_x;
        logic [MV_W-1:0]   vec_y;
        logic [MAW-1:0]    row;
        logic [MAW-1:0]    col;
        logic [SAD_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
        logic [MV_W-1:0]   run_x;
        logic [MV_W-1:0]   run_y;
        logic [SAD_W-1:0]  run_sad;
        logic [MV_W-1:0]   out_x;
        logic [MV_W-1:0]   out_y;
        logic [SAD_W-1:0]  out_sad;
        logic              done;
    } mvm_regs_t;

    mvm_regs_t st_d;
    mvm_regs_t st_q;

    // ------------------------------------------------------------------
    // Reference addressing
    // ------------------------------------------------------------------
    logic signed [MV_W-1:0]  int_x;
    logic signed [MV_W-1:0]  int_y;
    logic                    frac_x;
    logic                    frac_y;
    logic [IDX_W-1:0]        row_a;
    logic [IDX_W-1:0]        row_b;
    logic [IDX_W-1:0]        col_a;
    logic [IDX_W-1:0]        col_b;
    logic [3:0][RAW-1:0]     rd_row;
    logic [3:0][CAW-1:0]     rd_col;
    logic [3:0][PIX_W-1:0]   win_px;
    logic [PIX_W-1:0]        cur_px;
    logic [PIX_W-1:0]        abs_diff;
    logic                    cand_ok;

    assign int_x  = $signed(st_q.vec_x) >>> 1;
    assign int_y  = $signed(st_q.vec_y) >>> 1;
    assign frac_x = st_q.vec_x[0];
    assign frac_y = st_q.vec_y[0];

    assign row_a = IDX_W'(V_RANGE) + IDX_W'(st_q.row) + IDX_W'(int_y);
    assign col_a = IDX_W'(H_NEG) + IDX_W'(st_q.col) + IDX_W'(int_x);
    assign row_b = row_a + IDX_W'(frac_y);
    assign col_b = col_a + IDX_W'(frac_x);

    // Port order: A (row_a,col_a), B (row_a,col_b), C (row_b,col_a), D (row_b,col_b)
    assign rd_row[0] = RAW'(row_a);
    assign rd_col[0] = CAW'(col_a);
    assign rd_row[1] = RAW'(row_a);
    assign rd_col[1] = CAW'(col_b);
    assign rd_row[2] = RAW'(row_b);
    assign rd_col[2] = CAW'(col_a);
    assign rd_row[3] = RAW'(row_b);
    assign rd_col[3] = CAW'(col_b);

    mvm_store #(
        .ROWS (WIN_H),
        .COLS (WIN_W),
        .DW   (PIX_W),
        .NRD  (4)
    ) u_win_store (
        .clk     (clk),
        .we      (win_we),
        .wr_row  (win_row),
        .wr_col  (win_col),
        .wr_data (win_data),
        .rd_row  (rd_row),
        .rd_col  (rd_col),
        .rd_data (win_px)
    );

    mvm_store #(
        .ROWS (MB_DIM),
        .COLS (MB_DIM),
        .DW   (PIX_W),
        .NRD  (1)
    ) u_cur_store (
        .clk     (clk),
        .we      (cur_we),
        .wr_row  (cur_row),
        .wr_col  (cur_col),
        .wr_data (cur_data),
        .rd_row  (st_q.row),
        .rd_col  (st_q.col),
        .rd_data (cur_px)
    );

    mvm_halfpel #(
        .DW (PIX_W)
    ) u_halfpel (
        .s_a      (win_px[0]),
        .s_b      (win_px[1]),
        .s_c      (win_px[2]),
        .s_d      (win_px[3]),
        .frac_h   (frac_x),
        .frac_v   (frac_y),
        .cur_pix  (cur_px),
        .abs_diff (abs_diff)
    );

    mvm_range_check #(
        .MV_W    (MV_W),
        .H_NEG   (H_NEG),
        .H_POS   (H_POS),
        .V_RANGE (V_RANGE)
    ) u_range (
        .vec_x    (cand_x),
        .vec_y    (cand_y),
        .in_range (cand_ok)
    );

    // ------------------------------------------------------------------
    // Next-state logic
    // ------------------------------------------------------------------
    logic              commit;
    logic [SAD_W-1:0]  commit_sad;
    logic [MV_W-1:0]   commit_x;
    logic [MV_W-1:0]   commit_y;
    logic [SAD_W-1:0]  sad_next;
    logic              take_new;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        commit     = 1'b0;
        commit_sad = '0;
        commit_x   = st_q.vec_x;
        commit_y   = st_q.vec_y;
        sad_next   = st_q.acc + SAD_W'(abs_diff);
        take_new   = 1'b0;

        unique case (st_q.state)
            ST_IDLE: begin
                if (cand_valid) begin
                    st_d.vec_x = cand_x;
                    st_d.vec_y = cand_y;
                    if (cand_ok) begin
                        st_d.state = ST_SCORE;
                        st_d.row   = '0;
                        st_d.col   = '0;
                        st_d.acc   = '0;
                    end else begin
                        commit     = 1'b1;
                        commit_sad = '1;
                        commit_x   = cand_x;
                        commit_y   = cand_y;
                    end
                end
            end
            ST_SCORE: begin
                st_d.acc = sad_next;
                if (st_q.col == MAW'(MB_DIM - 1)) begin
                    st_d.col = '0;
                    if (st_q.row == MAW'(MB_DIM - 1)) begin
                        st_d.row   = '0;
                        st_d.state = ST_IDLE;
                        commit     = 1'b1;
                        commit_sad = sad_next;
                    end else begin
                        st_d.row = st_q.row + MAW'(1);
                    end
                end else begin
                    st_d.col = st_q.col + MAW'(1);
                end
            end
            default: st_d.state = ST_IDLE;
        endcase

        if (commit) begin
            // Strict comparison keeps the earlier candidate on a tie
            take_new = (st_q.cnt == '0) || (commit_sad < st_q.run_sad);
            if (take_new) begin
                st_d.run_x   = commit_x;
                st_d.run_y   = commit_y;
                st_d.run_sad = commit_sad;
            end
            if (st_q.cnt == CNT_W'(NUM_CAND - 1)) begin
                st_d.cnt     = '0;
                st_d.done    = 1'b1;
                st_d.out_x   = take_new ? commit_x   : st_q.run_x;
                st_d.out_y   = take_new ? commit_y   : st_q.run_y;
                st_d.out_sad = take_new ? commit_sad : st_q.run_sad;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cand_ready = (st_q.state == ST_IDLE);
    assign done       = st_q.done;
    assign best_x     = st_q.out_x;
    assign best_y     = st_q.out_y;
    assign best_sad   = st_q.out_sad;

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(best_sad) && $stable(best_x) && $stable(best_y))); // R6

    AST_REJECT_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_ready && !cand_ok) |=> cand_ready);            // R5

    AST_SCORE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_ready && cand_ok) |=> !cand_ready);            // R8

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_SCORE) |->
            (int'(st_q.acc) <= (int'(st_q.row) * MB_DIM + int'(st_q.col)) * PIX_MAX)); // R4

    AST_WIN_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        win_we |-> ((int'(win_row) < WIN_H) && (int'(win_col) < WIN_W)));  // R9

endmodule

// File: tb/tb_mv_cand_matcher.sv
`timescale 1ns/1ps
module tb_mv_cand_matcher;

    localparam int MB_DIM   = 4;
    localparam int V_RANGE  = 2;
    localparam int H_NEG    = 2;
    localparam int H_POS    = 1;
    localparam int NUM_CAND = 5;
    localparam int PIX_W    = 8;
    localparam int SAD_W    = 16;
    localparam int MV_W     = 6;
    localparam int WIN_H    = MB_DIM + 2 * V_RANGE;
    localparam int WIN_W    = MB_DIM + H_NEG + H_POS;
    localparam int RAW      = $clog2(WIN_H);
    localparam int CAW      = $clog2(WIN_W);
    localparam int MAW      = $clog2(MB_DIM);
    localparam int SAD_MAX  = (1 << SAD_W) - 1;
    localparam int NSWEEP   = 11 * 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              win_we = 1'b0;
    logic [RAW-1:0]    win_row = '0;
    logic [CAW-1:0]    win_col = '0;
    logic [PIX_W-1:0]  win_data = '0;
    logic              cur_we = 1'b0;
    logic [MAW-1:0]    cur_row = '0;
    logic [MAW-1:0]    cur_col = '0;
    logic [PIX_W-1:0]  cur_data = '0;
    logic              cand_valid = 1'b0;
    logic              cand_ready;
    logic [MV_W-1:0]   cand_x = '0;
    logic [MV_W-1:0]   cand_y = '0;
    logic              done;
    logic [MV_W-1:0]   best_x;
    logic [MV_W-1:0]   best_y;
    logic [SAD_W-1:0]  best_sad;

    int checks = 0;
    int errors = 0;
    int win_m [WIN_H][WIN_W];
    int cur_m [MB_DIM][MB_DIM];
    int sw_x [NSWEEP];
    int sw_y [NSWEEP];

    always #2.5 clk = ~clk;

    mv_cand_matcher #(
        .MB_DIM   (MB_DIM),
        .V_RANGE  (V_RANGE),
        .H_NEG    (H_NEG),
        .H_POS    (H_POS),
        .NUM_CAND (NUM_CAND),
        .PIX_W    (PIX_W),
        .SAD_W    (SAD_W),
        .MV_W     (MV_W)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_we     (win_we),
        .win_row    (win_row),
        .win_col    (win_col),
        .win_data   (win_data),
        .cur_we     (cur_we),
        .cur_row    (cur_row),
        .cur_col    (cur_col),
        .cur_data   (cur_data),
        .cand_valid (cand_valid),
        .cand_ready (cand_ready),
        .cand_x     (cand_x),
        .cand_y     (cand_y),
        .done       (done),
        .best_x     (best_x),
        .best_y     (best_y),
        .best_sad   (best_sad)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_result(input string req, input int ex, input int ey, input int es);
        int ax = int'($signed(best_x));
        int ay = int'($signed(best_y));
        int as_ = int'(best_sad);
        checks++;
        if (ax != ex || ay != ey || as_ != es) begin
            errors++;
            $display("FAIL %s actual (%0d,%0d,%0d) expected (%0d,%0d,%0d)",
                     req, ax, ay, as_, ex, ey, es);
        end
    endtask

    function automatic int win_pat(input int p, input int r, input int c);
        case (p)
            0:       return (r * 29 + c * 17) % 256;
            1:       return (r * r * 53 + c * 97 + r * c * 31 + 7) % 256;
            2:       return ((r + c) % 2 == 1) ? 255 : 0;
            default: return 100;
        endcase
    endfunction

    function automatic int cur_pat(input int p, input int r, input int c);
        case (p)
            0:       return (r * 41 + c * 19 + 60) % 256;
            1:       return (r * 113 + c * c * 71 + 5) % 256;
            2:       return ((r + c) % 2 == 1) ? 0 : 255;
            default: return 100;
        endcase
    endfunction

    function automatic bit in_win(input int x, input int y);
        return (x >= -2 * H_NEG) && (x <= 2 * H_POS) &&
               (y >= -2 * V_RANGE) && (y <= 2 * V_RANGE);
    endfunction

    function automatic int model_sad(input int x, input int y);
        int ix, iy, fx, fy, sum, a, b, c, d, pr, rr, cc, df;
        if (!in_win(x, y)) return SAD_MAX;
        ix = x >>> 1; iy = y >>> 1; fx = x & 1; fy = y & 1;
        sum = 0;
        for (int r = 0; r < MB_DIM; r++) begin
            for (int k = 0; k < MB_DIM; k++) begin
                rr = V_RANGE + r + iy;
                cc = H_NEG + k + ix;
                a = win_m[rr][cc];
                b = fx ? win_m[rr][cc + 1] : a;
                c = fy ? win_m[rr + 1][cc] : a;
                d = (fx && fy) ? win_m[rr + 1][cc + 1] : a;
                if (fx && fy)  pr = (a + b + c + d + 2) >> 2;
                else if (fx)   pr = (a + b + 1) >> 1;
                else if (fy)   pr = (a + c + 1) >> 1;
                else           pr = a;
                df = cur_m[r][k] - pr;
                sum += (df < 0) ? -df : df;
            end
        end
        return sum;
    endfunction

    task automatic write_win(input int r, input int c, input int v);
        @(negedge clk);
        win_we = 1'b1; win_row = RAW'(r); win_col = CAW'(c); win_data = PIX_W'(v);
        @(negedge clk);
        win_we = 1'b0;
        win_m[r][c] = v;
    endtask

    task automatic write_cur(input int r, input int c, input int v);
        @(negedge clk);
        cur_we = 1'b1; cur_row = MAW'(r); cur_col = MAW'(c); cur_data = PIX_W'(v);
        @(negedge clk);
        cur_we = 1'b0;
        cur_m[r][c] = v;
    endtask

    task automatic load_pattern(input int p);
        for (int r = 0; r < WIN_H; r++)
            for (int c = 0; c < WIN_W; c++)
                write_win(r, c, win_pat(p, r, c));
        for (int r = 0; r < MB_DIM; r++)
            for (int c = 0; c < MB_DIM; c++)
                write_cur(r, c, cur_pat(p, r, c));
    endtask

    task automatic send_cand(input int x, input int y);
        @(negedge clk);
        while (!cand_ready) @(negedge clk);
        cand_valid = 1'b1; cand_x = MV_W'(x); cand_y = MV_W'(y);
        @(negedge clk);
        cand_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, req, int'(done), 1);
    endtask

    task automatic run_set(input int xs[5], input int ys[5], input string req);
        int bi = 0;
        int s[5];
        for (int i = 0; i < 5; i++) begin
            send_cand(xs[i], ys[i]);
            s[i] = model_sad(xs[i], ys[i]);
        end
        wait_done(req);
        for (int i = 1; i < 5; i++) if (s[i] < s[bi]) bi = i;
        chk_result(req, xs[bi], ys[bi], s[bi]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int xs[5];
        int ys[5];
        int k;
        int gx, gy, gs, n;
        int sx, sy, ss;

        k = 0;
        for (int y = -6; y <= 6; y++)
            for (int x = -6; x <= 4; x++) begin
                sw_x[k] = x; sw_y[k] = y; k++;
            end

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cand_ready == 1'b1, "R1 ready", int'(cand_ready), 1);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk_result("R1 outputs", 0, 0, 0);

        for (int p = 0; p < 3; p++) begin
            load_pattern(p);
            // Each position alone, followed by four out-of-window fillers
            for (int i = 0; i < NSWEEP; i++) begin
                xs = '{sw_x[i], 20, 20, 20, 20};
                ys = '{sw_y[i], 20, 20, 20, 20};
                if (!in_win(sw_x[i], sw_y[i]))           run_set(xs, ys, "R5 reject");
                else if ((sw_x[i] & 1) || (sw_y[i] & 1)) run_set(xs, ys, "R3 halfpel");
                else if (p == 2)                         run_set(xs, ys, "R4 sad");
                else                                     run_set(xs, ys, "R2 integer");
            end
            // Sliding groups: minimum search
            for (int g = 0; g + 5 <= NSWEEP; g += 5) begin
                for (int i = 0; i < 5; i++) begin
                    xs[i] = sw_x[g + i]; ys[i] = sw_y[g + i];
                end
                run_set(xs, ys, "R7 minimum");
            end
        end

        // R9: single write changes the score of the (0,0) candidate
        write_win(V_RANGE + 1, H_NEG + 2, 200);
        xs = '{0, 20, 20, 20, 20}; ys = '{0, 20, 20, 20, 20};
        run_set(xs, ys, "R9 window write");
        write_cur(2, 1, 3);
        run_set(xs, ys, "R9 current write");

        // R8: busy length and ignored offers while busy
        load_pattern(1);
        gx = 0; gy = 0; gs = SAD_MAX + 1;
        for (int y = -2 * V_RANGE; y <= 2 * V_RANGE; y++)
            for (int x = -2 * H_NEG; x <= 2 * H_POS; x++)
                if (model_sad(x, y) < gs) begin
                    gs = model_sad(x, y); gx = x; gy = y;
                end
        xs = '{1, -1, 2, -3, 0}; ys = '{-1, 2, 3, 1, -4};
        @(negedge clk);
        while (!cand_ready) @(negedge clk);
        cand_valid = 1'b1; cand_x = MV_W'(xs[0]); cand_y = MV_W'(ys[0]);
        @(negedge clk);
        cand_x = MV_W'(gx); cand_y = MV_W'(gy);
        n = 0;
        while (!cand_ready && n < 100) begin
            n++;
            @(negedge clk);
        end
        cand_valid = 1'b0;
        chk(n == MB_DIM * MB_DIM, "R8 busy cycles", n, MB_DIM * MB_DIM);
        for (int i = 1; i < 5; i++) send_cand(xs[i], ys[i]);
        wait_done("R8 done");
        begin
            int bi = 0;
            for (int i = 1; i < 5; i++) if (model_sad(xs[i], ys[i]) < model_sad(xs[bi], ys[bi])) bi = i;
            chk_result("R8 ignored offer", xs[bi], ys[bi], model_sad(xs[bi], ys[bi]));
            sx = xs[bi]; sy = ys[bi]; ss = model_sad(xs[bi], ys[bi]);
        end

        // R6: pulse width and hold across a partial set
        @(negedge clk);
        chk(done == 1'b0, "R6 pulse width", int'(done), 0);
        send_cand(gx, gy);
        send_cand(20, 20);
        repeat (3) @(negedge clk);
        chk_result("R6 hold", sx, sy, ss);
        send_cand(0, 0);
        send_cand(1, 1);
        send_cand(-2, 0);
        wait_done("R6 done");
        chk_result("R6 new result", gx, gy, gs);

        // R7: ties on a flat picture and the all-rejected set
        load_pattern(3);
        xs = '{3, 1, -2, 0, 2}; ys = '{0, 1, 0, 0, -2};
        run_set(xs, ys, "R7 tie");
        chk_result("R7 tie first", 1, 1, 0);
        xs = '{-7, 5, 3, 0, 9}; ys = '{0, 0, 5, -6, 9};
        run_set(xs, ys, "R7 all rejected");
        chk_result("R7 all rejected first", -7, 0, SAD_MAX);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule